// File: doc/BRIEF.md
# Low-Power Wakeup Handshake Sequencer

This block sits on the controller side of a host link and brings a sleeping wireless controller back onto its UART. It runs entirely from the 32.768 kHz low-power clock. When the host raises its wake line, the sequencer requests the reference clock from the host. It then allows a programmable time for that clock to settle, and after a fixed extra latency it opens flow control by pulling its active-low RTS output low.

Traffic toward the host passes through two gates. A host-interrupt output mirrors the controller's pending-event flag in every state, including sleep, so the host learns that data is waiting. A transmit enable is granted only while the link is open and the host is holding its active-low CTS line low. When the host drops its wake line and nothing is pending, the sequencer closes RTS, withdraws the clock request and returns to sleep.

Top module: `lp_wake_seq`

## Requirements
- R1: While reset is held and right after it is released, clk_req_o is 0, rts_n_o is 1, tx_en_o is 0 and host_irq_o is 0.
- R2: From sleep, a rising edge on host_wake_i makes clk_req_o rise after the 4th lp_clk rising edge, counting the first edge that samples host_wake_i high. That count is two synchronizer stages plus a two-cycle request delay. clk_req_o is still 0 after the 3rd edge.
- R3: The settling wait lasts N = (3 + 3*code) * 33 lp_clk cycles, where code is settle_cfg_i sampled at the edge on which clk_req_o rises. This gives 3 ms to 39 ms in steps of 3 ms.
- R4: A settle_cfg_i value above 12 behaves exactly like 12, so N is 1287 cycles.
- R5: rts_n_o falls exactly N + 4 lp_clk edges after clk_req_o rises, and it is 1 at every sample before that.
- R6: tx_en_o is 1 only while rts_n_o is 0 and cts_n_i has been low at the sampling edge two cycles earlier. It rises on the 2nd edge after cts_n_i falls and drops on the 2nd edge after cts_n_i rises.
- R7: host_irq_o equals evt_pending_i as sampled on the previous lp_clk edge, in every state including sleep. A pending event on its own does not start a wakeup.
- R8: In any awake state, once host_wake_i has been low for 3 sampling edges and evt_pending_i is 0, clk_req_o drops to 0 and rts_n_o returns to 1 on that 3rd edge. After 2 edges they are unchanged.
- R9: While evt_pending_i is 1, the link stays open even with host_wake_i low. When evt_pending_i returns to 0, sleep is entered on the next edge.
- R10: A new rising edge on host_wake_i while the block is awake is ignored. The sequence does not restart and rts_n_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lp_clk | input | 1 | Low-power clock, 32.768 kHz |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with lp_clk |
| host_wake_i | input | 1 | Wake request from the host, asynchronous |
| cts_n_i | input | 1 | Active-low clear-to-send from the host, asynchronous |
| settle_cfg_i | input | 4 | Settling-delay code, 0..12, larger values saturate |
| evt_pending_i | input | 1 | Controller has events queued for the host |
| clk_req_o | output | 1 | Reference clock request to the host |
| rts_n_o | output | 1 | Active-low flow-on to the host |
| host_irq_o | output | 1 | Tells the host that events are waiting |
| tx_en_o | output | 1 | Permits queued traffic to be sent |

## Verification
The wakeup sequence is run with delay codes 0, 5, 12 and 15. The edge on which clk_req_o rises and the edge on which rts_n_o falls are checked together with the cycles just before them. Off-by-one errors in the request delay, the millisecond scaling, the 3 ms step and the saturation therefore each show up as a distinct failure. CTS is exercised both while the link is still closed and after it is open, which separates the RTS gating from the two-cycle synchronizer latency. Wake drops are tried during the settling wait, with and without a pending event, and with a re-raise of wake while open, which separates the abort, hold-open and ignore-re-wake paths.

// File: rtl/wkseq_pkg.sv
package wkseq_pkg;
  typedef enum logic [2:0] {
    WK_SLEEP  = 3'd0,
    WK_REQ    = 3'd1,
    WK_SETTLE = 3'd2,
    WK_FLOW   = 3'd3,
    WK_OPEN   = 3'd4
  } wk_state_e;
endpackage

// File: rtl/wkseq_sync.sv
// Multi-stage synchronizer for one asynchronous input bit.
module wkseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wkseq_timer.sv
// Loadable down-counter shared by every timed phase of the sequence.
module wkseq_timer #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = load_val_i;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/wkseq_fsm.sv
// Wake protocol state machine: request, settle, flow latency, open.
module wkseq_fsm
  import wkseq_pkg::*;
#(
  parameter int W          = 11,
  parameter int CFG_W      = 4,
  parameter int REQ_DLY    = 2,
  parameter int FLOW_LAT   = 4,
  parameter int CYC_PER_MS = 33,
  parameter int BASE_MS    = 3,
  parameter int STEP_MS    = 3,
  parameter int MAX_CODE   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_s_i,
  input  logic             cts_n_s_i,
  input  logic             evt_pending_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [W-1:0]     tmr_val_o,
  output logic             clk_req_o,
  output logic             rts_n_o,
  output logic             tx_en_o
);
  localparam logic [CFG_W-1:0] CODE_CAP = CFG_W'(MAX_CODE);

  wk_state_e        st_q, st_d;
  logic             wake_d_q;
  logic             wake_rise, go_sleep;
  logic [CFG_W-1:0] code_sat;
  logic [W-1:0]     settle_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= WK_SLEEP;
      wake_d_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      wake_d_q <= wake_s_i;
    end
  end

  assign wake_rise   = wake_s_i & ~wake_d_q;
  assign go_sleep    = ~wake_s_i & ~evt_pending_i;
  assign code_sat    = (cfg_i > CODE_CAP) ? CODE_CAP : cfg_i;
  assign settle_last = W'((BASE_MS + STEP_MS * int'(code_sat)) * CYC_PER_MS - 1);

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (st_q)
      WK_SLEEP: begin
        if (wake_rise) begin
          st_d       = WK_REQ;
          tmr_load_o = 1'b1;
          tmr_val_o  = W'(REQ_DLY - 2);
        end
      end
      WK_REQ: begin
        if (go_sleep) st_d = WK_SLEEP;
        else if (tmr_zero_i) begin
          st_d       = WK_SETTLE;
          tmr_load_o = 1'b1;
          tmr_val_o  = settle_last;
        end
      end
      WK_SETTLE: begin
        if (go_sleep) st_d = WK_SLEEP;
        else if (tmr_zero_i) begin
          st_d       = WK_FLOW;
          tmr_load_o = 1'b1;
          tmr_val_o  = W'(FLOW_LAT - 1);
        end
      end
      WK_FLOW: begin
        if (go_sleep)        st_d = WK_SLEEP;
        else if (tmr_zero_i) st_d = WK_OPEN;
      end
      WK_OPEN: begin
        if (go_sleep) st_d = WK_SLEEP;
      end
      default: st_d = WK_SLEEP;
    endcase
  end

  assign clk_req_o = (st_q == WK_SETTLE) || (st_q == WK_FLOW) || (st_q == WK_OPEN);
  assign rts_n_o   = (st_q != WK_OPEN);
  assign tx_en_o   = (st_q == WK_OPEN) && !cts_n_s_i;
endmodule

// File: rtl/lp_wake_seq.sv
module lp_wake_seq #(
  parameter int CFG_W      = 4,
  parameter int SYNC_STG   = 2,
  parameter int REQ_DLY    = 2,
  parameter int FLOW_LAT   = 4,
  parameter int CYC_PER_MS = 33,
  parameter int BASE_MS    = 3,
  parameter int STEP_MS    = 3,
  parameter int MAX_CODE   = 12
) (
  input  logic             lp_clk,
  input  logic             rst_n,
  input  logic             host_wake_i,
  input  logic             cts_n_i,
  input  logic [CFG_W-1:0] settle_cfg_i,
  input  logic             evt_pending_i,
  output logic             clk_req_o,
  output logic             rts_n_o,
  output logic             host_irq_o,
  output logic             tx_en_o
);
  localparam int MAX_CYC = (BASE_MS + STEP_MS * MAX_CODE) * CYC_PER_MS;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  logic             wake_s, cts_n_s;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;

  wkseq_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_wake_sync (
    .clk(lp_clk), .rst_n(rst_n), .d_i(host_wake_i), .q_o(wake_s)
  );

  wkseq_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_cts_sync (
    .clk(lp_clk), .rst_n(rst_n), .d_i(cts_n_i), .q_o(cts_n_s)
  );

  wkseq_timer #(.W(TMR_W)) u_timer (
    .clk(lp_clk), .rst_n(rst_n), .load_i(tmr_load),
    .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  wkseq_fsm #(
    .W(TMR_W), .CFG_W(CFG_W), .REQ_DLY(REQ_DLY), .FLOW_LAT(FLOW_LAT),
    .CYC_PER_MS(CYC_PER_MS), .BASE_MS(BASE_MS), .STEP_MS(STEP_MS),
    .MAX_CODE(MAX_CODE)
  ) u_fsm (
    .clk(lp_clk), .rst_n(rst_n), .wake_s_i(wake_s), .cts_n_s_i(cts_n_s),
    .evt_pending_i(evt_pending_i), .cfg_i(settle_cfg_i),
    .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .clk_req_o(clk_req_o), .rts_n_o(rts_n_o), .tx_en_o(tx_en_o)
  );

  // Host interrupt mirrors the pending flag in every state.
  logic irq_d;
  assign irq_d = evt_pending_i;

  always_ff @(posedge lp_clk or negedge rst_n) begin
    if (!rst_n) host_irq_o <= 1'b0;
    else        host_irq_o <= irq_d;
  end
endmodule

// File: rtl/wkseq_chk.sv
module wkseq_chk (
  input logic lp_clk,
  input logic rst_n,
  input logic cts_n_i,
  input logic evt_pending_i,
  input logic clk_req_o,
  input logic rts_n_o,
  input logic host_irq_o,
  input logic tx_en_o
);
  // R5: flow is never on without the clock request
  a_r5_rts_needs_req: assert property (@(posedge lp_clk) disable iff (!rst_n)
    !clk_req_o |-> rts_n_o);

  // R5: RTS only falls after the clock request has been up
  a_r5_rts_fall_after_req: assert property (@(posedge lp_clk) disable iff (!rst_n)
    $fell(rts_n_o) |-> $past(clk_req_o));

  // R6: transmit only while flow is on
  a_r6_tx_needs_rts: assert property (@(posedge lp_clk) disable iff (!rst_n)
    tx_en_o |-> !rts_n_o);

  // R6: transmit only when CTS was low two edges ago
  a_r6_tx_needs_cts: assert property (@(posedge lp_clk) disable iff (!rst_n)
    tx_en_o |-> !$past(cts_n_i, 2));

  // R7: interrupt follows pending flag one edge later
  a_r7_irq_set: assert property (@(posedge lp_clk) disable iff (!rst_n)
    evt_pending_i |=> host_irq_o);
  a_r7_irq_clr: assert property (@(posedge lp_clk) disable iff (!rst_n)
    !evt_pending_i |=> !host_irq_o);

  // R8: RTS closes only together with dropping the clock request
  a_r8_close_with_sleep: assert property (@(posedge lp_clk) disable iff (!rst_n)
    $rose(rts_n_o) |-> !clk_req_o);
endmodule

bind lp_wake_seq wkseq_chk u_chk (
  .lp_clk(lp_clk), .rst_n(rst_n), .cts_n_i(cts_n_i),
  .evt_pending_i(evt_pending_i), .clk_req_o(clk_req_o), .rts_n_o(rts_n_o),
  .host_irq_o(host_irq_o), .tx_en_o(tx_en_o)
);

// File: tb/lp_wake_seq_test.sv
module lp_wake_seq_test;
  localparam int CLK_PERIOD = 10;

  logic       lp_clk, rst_n, host_wake_i, cts_n_i, evt_pending_i;
  logic [3:0] settle_cfg_i;
  logic       clk_req_o, rts_n_o, host_irq_o, tx_en_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  lp_wake_seq uut (
    .lp_clk(lp_clk), .rst_n(rst_n), .host_wake_i(host_wake_i),
    .cts_n_i(cts_n_i), .settle_cfg_i(settle_cfg_i),
    .evt_pending_i(evt_pending_i), .clk_req_o(clk_req_o),
    .rts_n_o(rts_n_o), .host_irq_o(host_irq_o), .tx_en_o(tx_en_o)
  );

  initial lp_clk = 1'b0;
  always #(CLK_PERIOD/2) lp_clk = ~lp_clk;

  task automatic tick(input int n);
    repeat (n) @(negedge lp_clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int settle_n(input int code);
    int c;
    c = (code > 12) ? 12 : code;
    return (3 + 3 * c) * 33;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; host_wake_i = 1'b0; cts_n_i = 1'b1;
    evt_pending_i = 1'b0; settle_cfg_i = 4'd0;
    tick(3);
    chk("R1", "clk_req in reset", clk_req_o, 1'b0);
    chk("R1", "rts_n in reset", rts_n_o, 1'b1);
    rst_n = 1'b1;
    tick(2);
    chk("R1", "clk_req", clk_req_o, 1'b0);
    chk("R1", "rts_n", rts_n_o, 1'b1);
    chk("R1", "tx_en", tx_en_o, 1'b0);
    chk("R1", "host_irq", host_irq_o, 1'b0);
  endtask

  // Full wakeup from sleep; ends with the link open and wake high.
  task automatic t_wake(input int code, input string req_n);
    int n;
    n = settle_n(code);
    settle_cfg_i = 4'(code);
    host_wake_i  = 1'b1;
    tick(3);
    chk("R2", "clk_req before 4th edge", clk_req_o, 1'b0);
    tick(1);
    chk("R2", "clk_req on 4th edge", clk_req_o, 1'b1);
    chk(req_n, "rts_n at settle start", rts_n_o, 1'b1);
    tick(n / 2);
    chk("R6", "tx_en while link closed", tx_en_o, 1'b0);
    tick(n + 3 - n / 2);
    chk(req_n, "rts_n one edge before N+4", rts_n_o, 1'b1);
    chk("R5", "rts_n one edge before N+4", rts_n_o, 1'b1);
    tick(1);
    chk(req_n, "rts_n at N+4", rts_n_o, 1'b0);
    chk("R5", "rts_n at N+4", rts_n_o, 1'b0);
    chk("R6", "tx_en on open", tx_en_o, !cts_n_i);
  endtask

  task automatic t_sleep();
    host_wake_i = 1'b0; evt_pending_i = 1'b0;
    tick(2);
    chk("R8", "clk_req after 2 edges", clk_req_o, 1'b1);
    tick(1);
    chk("R8", "clk_req after 3 edges", clk_req_o, 1'b0);
    chk("R8", "rts_n after 3 edges", rts_n_o, 1'b1);
    tick(4);
  endtask

  task automatic t_cts();
    cts_n_i = 1'b0;
    tick(1);
    chk("R6", "tx_en 1 edge after CTS low", tx_en_o, 1'b0);
    tick(1);
    chk("R6", "tx_en 2 edges after CTS low", tx_en_o, 1'b1);
    cts_n_i = 1'b1;
    tick(1);
    chk("R6", "tx_en 1 edge after CTS high", tx_en_o, 1'b1);
    tick(1);
    chk("R6", "tx_en 2 edges after CTS high", tx_en_o, 1'b0);
  endtask

  task automatic t_irq_sleep();
    evt_pending_i = 1'b1;
    tick(1);
    chk("R7", "host_irq set in sleep", host_irq_o, 1'b1);
    tick(6);
    chk("R7", "pending alone does not wake", clk_req_o, 1'b0);
    evt_pending_i = 1'b0;
    tick(1);
    chk("R7", "host_irq clear", host_irq_o, 1'b0);
  endtask

  task automatic t_hold();
    evt_pending_i = 1'b1; host_wake_i = 1'b0;
    tick(6);
    chk("R9", "open while pending", rts_n_o, 1'b0);
    host_wake_i = 1'b1;
    tick(8);
    chk("R10", "re-wake ignored rts_n", rts_n_o, 1'b0);
    chk("R10", "re-wake ignored clk_req", clk_req_o, 1'b1);
    host_wake_i = 1'b0;
    tick(4);
    chk("R9", "still open, wake low", rts_n_o, 1'b0);
    evt_pending_i = 1'b0;
    tick(1);
    chk("R9", "sleep after pending clears rts_n", rts_n_o, 1'b1);
    chk("R9", "sleep after pending clears clk_req", clk_req_o, 1'b0);
    tick(4);
  endtask

  task automatic t_abort();
    settle_cfg_i = 4'd3;
    host_wake_i  = 1'b1;
    tick(4);
    chk("R2", "clk_req up before abort", clk_req_o, 1'b1);
    tick(20);
    host_wake_i = 1'b0;
    tick(2);
    chk("R8", "abort: clk_req after 2 edges", clk_req_o, 1'b1);
    tick(1);
    chk("R8", "abort: clk_req after 3 edges", clk_req_o, 1'b0);
    chk("R8", "abort: rts_n", rts_n_o, 1'b1);
    tick(400);
    chk("R8", "abort: stays asleep", rts_n_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_irq_sleep();
    t_wake(0, "R3");
    t_cts();
    t_sleep();
    cts_n_i = 1'b0;
    t_wake(5, "R3");
    cts_n_i = 1'b1;
    tick(2);
    t_hold();
    t_wake(12, "R3");
    t_sleep();
    t_wake(15, "R4");
    t_sleep();
    t_abort();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge lp_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule